// File: doc/BRIEF.md
# Migratory Sharing Detector

This unit sits next to a home directory and looks for cache lines whose data travels from one processor to the next. In that pattern each node reads the line and then writes it. The unit receives two streams. The first is a stream of observed accesses, each giving a line index, a node and whether the access was a read or a write. The second is the stream of incoming coherence requests.

For each line the unit keeps a small history: the last writer, a candidate reader, a saturating count of migrations seen and a conversion flag. Once the count reaches a threshold, the line is flagged. From then on, a plain read request to that line leaves the unit as a read-exclusive request. The requester then gets the line ready for its coming store and avoids a second miss.

An owner that holds a converted line may see another node's request arrive before it has written the line. That owner sends a revert notice. The revert wipes the line's history and flag, and the line can be flagged again if the pattern returns. All other request kinds pass through unchanged after one register stage.

Top module: `migratory_detector`

## Requirements
- R1: After reset every per-line count is 0, every flag is 0 and `rsp_valid` is 0.
- R2: A migration is counted on a line when a node other than the last recorded writer reads it and that same node then writes it, with no read by a third node in between. A write without such a read, or a read by the last writer, adds nothing. Every write records its node as the last writer.
- R3: The per-line count saturates at THRESH (default 2). Line i's count is found in `mig_counts[i*CW +: CW]`, where CW = $clog2(THRESH+1) (2 by default).
- R4: A line's flag in `mig_flags[i]` is set in the same cycle its count first reaches THRESH, and it stays set until a revert.
- R5: Request type encoding: 0 read, 1 read-exclusive, 2 upgrade, 3 writeback. A read (0) to a flagged line appears one cycle later as read-exclusive (1), with `rsp_converted` = 1.
- R6: Every other request, and a read to an unflagged line, appears one cycle later with its type unchanged and `rsp_converted` = 0. Line and node are also unchanged. `rsp_valid` follows `req_valid` with one cycle of delay.
- R7: A revert on a line clears its count, flag, last writer and candidate reader. If an observation to the same line arrives in the same cycle, the revert takes precedence.
- R8: After a revert, a line is flagged again once THRESH new migrations are observed.
- R9: Observations, requests and reverts on one line leave every other line's count and flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| obs_valid | input | 1 | Observed access present |
| obs_line | input | LINE_W | Line index of the observed access |
| obs_node | input | NODE_W | Node that performed the access |
| obs_write | input | 1 | 1 = write, 0 = read |
| req_valid | input | 1 | Incoming request present |
| req_line | input | LINE_W | Line targeted by the request |
| req_node | input | NODE_W | Requesting node |
| req_type | input | 2 | Request type (0 read, 1 read-exclusive, 2 upgrade, 3 writeback) |
| rev_valid | input | 1 | Revert notice present |
| rev_line | input | LINE_W | Line whose conversion is withdrawn |
| rsp_valid | output | 1 | Translated request valid |
| rsp_line | output | LINE_W | Line of the translated request |
| rsp_node | output | NODE_W | Node of the translated request |
| rsp_type | output | 2 | Translated request type |
| rsp_converted | output | 1 | Request was changed from read to read-exclusive |
| mig_flags | output | NUM_LINES | Per-line conversion flags |
| mig_counts | output | NUM_LINES*CW | Per-line migration counts, packed |

## Verification
Some properties are checked on every cycle. The count never passes THRESH. A flag rises only in a cycle that follows a detected migration. A revert leaves the line with a zero count and a clear flag. The translation stage turns a read to a flagged line into read-exclusive, passes every other type unchanged, and never emits a response without a request one cycle earlier. The bench scenarios are needed for the rest. These are the exact order that counts as a migration, including the cases where a third reader breaks it, a writer re-reads its own line, or the last-writer record was just cleared. They also cover re-designation after a revert, the revert winning over a same-cycle observation, and the isolation of one line from another.

// File: rtl/mig_pkg.sv
package mig_pkg;

  localparam logic [1:0] REQ_READ  = 2'd0;
  localparam logic [1:0] REQ_READX = 2'd1;
  localparam logic [1:0] REQ_UPG   = 2'd2;
  localparam logic [1:0] REQ_WB    = 2'd3;

  // Saturating increment, done in int so the caller picks the width.
  function automatic int sat_inc(input int value, input int limit);
    return (value >= limit) ? limit : value + 1;
  endfunction

  // Request type translation for a line with the given flag.
  function automatic logic [1:0] xlate_type(input logic [1:0] kind, input logic flagged);
    return (kind == REQ_READ && flagged) ? REQ_READX : kind;
  endfunction

endpackage

// File: rtl/mig_line_track.sv
module mig_line_track #(
  parameter int NODE_W = 3,
  parameter int THRESH = 2,
  parameter int CW     = $clog2(THRESH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              obs_hit,
  input  logic [NODE_W-1:0] obs_node,
  input  logic              obs_write,
  input  logic              rev_hit,
  output logic              flag,
  output logic [CW-1:0]     cnt,
  output logic              mig_event
);
  import mig_pkg::*;

  logic [NODE_W-1:0] lw_node_q;
  logic              lw_valid_q;
  logic [NODE_W-1:0] rd_node_q;
  logic              rd_valid_q;
  logic [CW-1:0]     cnt_q;
  logic              flag_q;
  int                cnt_next;

  // Named internal events for the assertions.
  assign mig_event = obs_hit && obs_write && rd_valid_q &&
                     (rd_node_q == obs_node) && !rev_hit;
  assign cnt_next  = sat_inc(int'(cnt_q), THRESH);

  always_ff @(posedge clk) begin
    if (!rst_n || rev_hit) begin
      lw_node_q  <= '0;
      lw_valid_q <= 1'b0;
      rd_node_q  <= '0;
      rd_valid_q <= 1'b0;
      cnt_q      <= '0;
      flag_q     <= 1'b0;
    end else if (obs_hit) begin
      if (obs_write) begin
        lw_node_q  <= obs_node;
        lw_valid_q <= 1'b1;
        rd_valid_q <= 1'b0;
        if (mig_event) begin
          cnt_q  <= CW'(cnt_next);
          flag_q <= flag_q | (cnt_next >= THRESH);
        end
      end else if (rd_valid_q) begin
        if (rd_node_q != obs_node) rd_valid_q <= 1'b0;
      end else if (lw_valid_q && (obs_node != lw_node_q)) begin
        rd_valid_q <= 1'b1;
        rd_node_q  <= obs_node;
      end
    end
  end

  assign flag = flag_q;
  assign cnt  = cnt_q;

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= THRESH);

  assert_flag_needs_migration_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(mig_event));

  assert_revert_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rev_hit |=> (cnt_q == '0 && !flag_q));

endmodule

// File: rtl/mig_req_xlate.sv
module mig_req_xlate #(
  parameter int LINE_W = 4,
  parameter int NODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [LINE_W-1:0] in_line,
  input  logic [NODE_W-1:0] in_node,
  input  logic [1:0]        in_type,
  input  logic              line_flag,
  output logic              out_valid,
  output logic [LINE_W-1:0] out_line,
  output logic [NODE_W-1:0] out_node,
  output logic [1:0]        out_type,
  output logic              out_conv
);
  import mig_pkg::*;

  logic [1:0] next_type;
  assign next_type = xlate_type(in_type, line_flag);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_line  <= '0;
      out_node  <= '0;
      out_type  <= REQ_READ;
      out_conv  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      out_line  <= in_line;
      out_node  <= in_node;
      out_type  <= next_type;
      out_conv  <= in_valid && (next_type != in_type);
    end
  end

  assert_read_converted_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_type == REQ_READ && line_flag) |=>
      (out_valid && out_type == REQ_READX && out_conv));

  assert_other_passthru_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_type != REQ_READ) |=>
      (out_valid && out_type == $past(in_type) && !out_conv));

  assert_no_spurious_rsp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

endmodule

// File: rtl/migratory_detector.sv
module migratory_detector #(
  parameter int NUM_LINES = 16,
  parameter int NODE_W    = 3,
  parameter int THRESH    = 2,
  parameter int LINE_W    = $clog2(NUM_LINES),
  parameter int CW        = $clog2(THRESH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    obs_valid,
  input  logic [LINE_W-1:0]       obs_line,
  input  logic [NODE_W-1:0]       obs_node,
  input  logic                    obs_write,
  input  logic                    req_valid,
  input  logic [LINE_W-1:0]       req_line,
  input  logic [NODE_W-1:0]       req_node,
  input  logic [1:0]              req_type,
  input  logic                    rev_valid,
  input  logic [LINE_W-1:0]       rev_line,
  output logic                    rsp_valid,
  output logic [LINE_W-1:0]       rsp_line,
  output logic [NODE_W-1:0]       rsp_node,
  output logic [1:0]              rsp_type,
  output logic                    rsp_converted,
  output logic [NUM_LINES-1:0]    mig_flags,
  output logic [NUM_LINES*CW-1:0] mig_counts
);

  logic [NUM_LINES-1:0] mig_events;
  logic [NUM_LINES-1:0] rev_hits;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic obs_hit;
    assign obs_hit     = obs_valid && (obs_line == LINE_W'(i));
    assign rev_hits[i] = rev_valid && (rev_line == LINE_W'(i));

    mig_line_track #(
      .NODE_W (NODE_W),
      .THRESH (THRESH),
      .CW     (CW)
    ) u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .obs_hit   (obs_hit),
      .obs_node  (obs_node),
      .obs_write (obs_write),
      .rev_hit   (rev_hits[i]),
      .flag      (mig_flags[i]),
      .cnt       (mig_counts[i*CW +: CW]),
      .mig_event (mig_events[i])
    );
  end

  mig_req_xlate #(
    .LINE_W (LINE_W),
    .NODE_W (NODE_W)
  ) u_xlate (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_line   (req_line),
    .in_node   (req_node),
    .in_type   (req_type),
    .line_flag (mig_flags[req_line]),
    .out_valid (rsp_valid),
    .out_line  (rsp_line),
    .out_node  (rsp_node),
    .out_type  (rsp_type),
    .out_conv  (rsp_converted)
  );

  // At most one line sees a migration or a revert per cycle (R9).
  assert_one_line_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mig_events) && $onehot0(rev_hits));

endmodule

// File: tb/migratory_detector_tb_top.sv
`timescale 1ns/1ps
module migratory_detector_tb_top;

  localparam int NUM_LINES = 16;
  localparam int NODE_W    = 3;
  localparam int THRESH    = 2;
  localparam int LINE_W    = 4;
  localparam int CW        = 2;

  // Vector: {kind, line, node, arg, exp_type, exp_flag, exp_cnt}
  // kind 0 observe (arg 1 write / 0 read), 1 request (arg = type), 2 revert
  function automatic logic [15:0] mk(input int kind, input int line, input int node,
                                     input int arg, input int et, input int ef, input int ec);
    return {2'(kind), 4'(line), 3'(node), 2'(arg), 2'(et), 1'(ef), 2'(ec)};
  endfunction

  localparam int NV = 26;
  localparam logic [15:0] VEC [NV] = '{
    mk(0,3,1,1,0,0,0),  // R2 first write records writer
    mk(1,3,2,0,0,0,0),  // R6 read of unflagged line stays read
    mk(0,3,2,0,0,0,0),
    mk(0,3,2,1,0,0,1),  // R2 first migration
    mk(0,3,4,0,0,0,1),
    mk(0,3,4,1,0,1,2),  // R4 threshold reached
    mk(1,3,5,0,1,1,2),  // R5 read converted
    mk(1,3,5,2,2,1,2),  // R6 upgrade unchanged
    mk(1,3,5,3,3,1,2),  // R6 writeback unchanged
    mk(1,5,5,0,0,0,0),  // R9 other line untouched
    mk(0,3,5,0,0,1,2),
    mk(0,3,5,1,0,1,2),  // R3 saturation
    mk(2,3,0,0,0,0,0),  // R7 revert
    mk(1,3,1,0,0,0,0),  // R7 read no longer converted
    mk(0,3,6,1,0,0,0),
    mk(0,3,6,0,0,0,0),  // R2 read by last writer
    mk(0,3,6,1,0,0,0),  // R2 no count
    mk(0,3,7,0,0,0,0),
    mk(0,3,1,0,0,0,0),  // R2 third reader breaks pattern
    mk(0,3,7,1,0,0,0),  // R2 no count
    mk(0,3,0,0,0,0,0),
    mk(0,3,0,1,0,0,1),  // R8 counting again
    mk(0,3,2,0,0,0,1),
    mk(0,3,2,1,0,1,2),  // R8 re-designated
    mk(1,3,4,0,1,1,2),  // R8 converted again
    mk(1,5,4,1,1,0,0)   // R9 read-exclusive passes, line 5 clear
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic obs_valid = 1'b0, obs_write = 1'b0;
  logic [LINE_W-1:0] obs_line = '0, req_line = '0, rev_line = '0;
  logic [NODE_W-1:0] obs_node = '0, req_node = '0;
  logic req_valid = 1'b0, rev_valid = 1'b0;
  logic [1:0] req_type = '0;
  logic rsp_valid, rsp_converted;
  logic [LINE_W-1:0] rsp_line;
  logic [NODE_W-1:0] rsp_node;
  logic [1:0] rsp_type;
  logic [NUM_LINES-1:0] mig_flags;
  logic [NUM_LINES*CW-1:0] mig_counts;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  migratory_detector #(
    .NUM_LINES (NUM_LINES), .NODE_W (NODE_W), .THRESH (THRESH)
  ) dut_i (
    .clk (clk), .rst_n (rst_n),
    .obs_valid (obs_valid), .obs_line (obs_line), .obs_node (obs_node), .obs_write (obs_write),
    .req_valid (req_valid), .req_line (req_line), .req_node (req_node), .req_type (req_type),
    .rev_valid (rev_valid), .rev_line (rev_line),
    .rsp_valid (rsp_valid), .rsp_line (rsp_line), .rsp_node (rsp_node), .rsp_type (rsp_type),
    .rsp_converted (rsp_converted), .mig_flags (mig_flags), .mig_counts (mig_counts)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int cnt_of(input int line);
    return int'(mig_counts[line*CW +: CW]);
  endfunction

  task automatic idle();
    obs_valid = 1'b0; req_valid = 1'b0; rev_valid = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(mig_flags == '0, "R1 flags", int'(mig_flags), 0);
    check(mig_counts == '0, "R1 counts", int'(mig_counts), 0);
    check(rsp_valid == 1'b0, "R1 rsp_valid", int'(rsp_valid), 0);

    for (int k = 0; k < NV; k++) begin
      logic [15:0] v;
      int kind, line, node, arg, et, ef, ec;
      v = VEC[k];
      kind = int'(v[15:14]); line = int'(v[13:10]); node = int'(v[9:7]);
      arg = int'(v[6:5]); et = int'(v[4:3]); ef = int'(v[2]); ec = int'(v[1:0]);
      @(negedge clk);
      idle();
      case (kind)
        0: begin obs_valid = 1'b1; obs_line = 4'(line); obs_node = 3'(node); obs_write = arg[0]; end
        1: begin req_valid = 1'b1; req_line = 4'(line); req_node = 3'(node); req_type = 2'(arg); end
        default: begin rev_valid = 1'b1; rev_line = 4'(line); end
      endcase
      @(posedge clk);
      #1;
      idle();
      check(mig_flags[line] == ef[0], "R2 R4 R7 R8 flag", int'(mig_flags[line]), ef);
      check(cnt_of(line) == ec, "R2 R3 R7 R8 count", cnt_of(line), ec);
      if (kind == 1) begin
        check(rsp_valid == 1'b1, "R6 rsp_valid", int'(rsp_valid), 1);
        check(int'(rsp_type) == et, "R5 R6 rsp_type", int'(rsp_type), et);
        check(rsp_converted == (arg == 0 && et == 1), "R5 R6 converted",
              int'(rsp_converted), int'(arg == 0 && et == 1));
        check(int'(rsp_line) == line && int'(rsp_node) == node, "R6 line/node",
              int'(rsp_line), line);
      end else begin
        check(rsp_valid == 1'b0, "R6 no rsp", int'(rsp_valid), 0);
      end
    end

    // R7: revert wins over a same-cycle migration-completing write.
    @(negedge clk);
    obs_valid = 1'b1; obs_line = 4'd3; obs_node = 3'd3; obs_write = 1'b0;
    @(negedge clk);
    obs_write = 1'b1; rev_valid = 1'b1; rev_line = 4'd3;
    @(posedge clk);
    #1;
    idle();
    check(mig_flags[3] == 1'b0, "R7 flag after revert+obs", int'(mig_flags[3]), 0);
    check(cnt_of(3) == 0, "R7 count after revert+obs", cnt_of(3), 0);
    check(cnt_of(5) == 0 && mig_flags[5] == 1'b0, "R9 line5 untouched", cnt_of(5), 0);

    // R1: mid-run reset after building a count on line 15.
    @(negedge clk); obs_valid = 1'b1; obs_line = 4'd15; obs_node = 3'd1; obs_write = 1'b1;
    @(negedge clk); obs_node = 3'd2; obs_write = 1'b0;
    @(negedge clk); obs_write = 1'b1;
    @(negedge clk); idle();
    check(cnt_of(15) == 1, "R2 line15 count", cnt_of(15), 1);
    req_valid = 1'b1; req_type = 2'd0; req_line = 4'd15;
    rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    idle();
    rst_n = 1'b1;
    @(negedge clk);
    check(mig_counts == '0, "R1 counts after reset", cnt_of(15), 0);
    check(rsp_valid == 1'b0, "R1 rsp_valid after reset", int'(rsp_valid), 0);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end

endmodule